// File: doc/BRIEF.md
# Programmable Chip-Select Timing Controller

This block sits between a processor's external bus master and a set of static-timing peripherals such as flash or FPGA register windows. It compares each request address against a configurable number of banks. Each bank has a base word and an option word, and both are written through a one-word register port. When a bank claims the address, the block drives that bank's active-low chip select and the read strobe or the write strobe. It holds them for a programmed number of wait states and then returns a one-cycle acknowledge. When no bank claims the address, the block drives no strobe and reports a bus error after a fixed timeout.

The block is clocked at four times the bus rate, so one bus clock is four ticks. This lets chip-select setup delays of a quarter or a half bus clock, and early negation, be placed on exact ticks. Requests use a valid/ready handshake. `req_ready` is high only while the block is idle, and a request is accepted on the rising edge where `req_valid` and `req_ready` are both high. The address and write flag must be held stable up to that edge. Responses (`bus_ack`, `bus_err`) are single-tick pulses with no back-pressure. The master must take them in the tick they appear.

Bank timing parameters are captured when a request is accepted. The external acknowledge input passes through one register before it is used. Bursting is never performed: the burst-inhibit bit is only reported outward.

Top module: `cs_timing_ctrl`

## Requirements
- R1: After reset all chip selects, `oe_n` and `we_n` are high, `req_ready` is high, and `bus_ack` and `bus_err` are low.
- R2: The base word and the option word layouts are as follows.
  - The base word holds the bank address in bits 31:15, the port size in bits 11:10, the machine select in bits 7:6 and valid in bit 0.
  - The option word holds the compare mask in bits 31:15.
  - A bank claims an address when its valid bit is 1 and its machine select is 0, and when (address XOR base) AND mask is zero over bits 31:15. Address bits 14:0 never take part.
  - When several banks claim an address, the lowest-numbered bank is chosen.
  - At most one chip select is low at any time.
- R3: With external acknowledge off, an access lasts 4*(1+W) ticks, where W is the wait count in option bits 7:4. `bus_ack` is high in the last tick. Tick 0 is the first tick after acceptance.
- R4: Option bit 2 (relaxed) doubles W, giving 4*(1+2*W) ticks.
- R5: Option bits 10:9 set the chip-select setup delay.
  - Values 0 and 1 assert the chip select in tick 0.
  - Value 2 asserts it in tick 1 (a quarter clock late).
  - Value 3 asserts it in tick 2 (a half clock late).
  - The read strobe starts together with the chip select.
- R6: With option bit 11 set and external acknowledge off, the chip select and the write strobe go high in the last tick of the access. The read strobe still lasts to the end of the access.
- R7: `oe_n` is driven low only for reads, and `we_n` only for writes. The two are never low together.
- R8: With option bit 1 set on the selected bank, four idle ticks precede the access when the previous acknowledged access was to a different bank. No idle ticks are added for the same bank or for the first access after reset.
- R9: With option bit 3 set, the access ends with `bus_ack` in the first tick, from tick 3 on, in which the registered external acknowledge is high. The chip select stays asserted through that tick, and option bit 11 has no effect.
- R10: When no bank claims the address, no strobe is driven and `bus_err` pulses in tick TIMEOUT-1. The same error ends an externally acknowledged access that sees no acknowledge by then. `bus_ack` and `bus_err` are never high together.
- R11: `req_ready` is low from acceptance until the tick after the response. While the block is idle, no strobe is active.
- R12: During an access, `port_size` shows base bits 11:10 of the selected bank, and `burst_inh` shows option bit 8.
- R13: A register write uses `reg_sel` = bank*2 + 1 for the option word and bank*2 for the base word. It takes effect for requests accepted after it, and it does not change an access already in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock, four ticks per bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | BANK_W+1 | Bank number and word select (bit 0: 1 = option) |
| reg_wdata | input | 32 | Register write data |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request ready (idle) |
| req_addr | input | 32 | Request address |
| req_write | input | 1 | 1 = write, 0 = read |
| ext_ack | input | 1 | External transfer acknowledge |
| cs_n | output | NBANK | Active-low chip select per bank |
| oe_n | output | 1 | Active-low read strobe |
| we_n | output | 1 | Active-low write strobe |
| port_size | output | 2 | Port size of the selected bank |
| burst_inh | output | 1 | Burst-inhibit bit of the selected bank |
| bus_ack | output | 1 | Transfer acknowledge pulse |
| bus_err | output | 1 | Bus error pulse |

## Verification
The embedded assertions check on every tick that the cross-cutting invariants hold:
- at most one chip select is low;
- the two strobes are exclusive;
- acknowledge and error are exclusive;
- the block is silent while ready;
- an acknowledge is always followed by a return to idle;
- the bank-change idle gap is exactly four ticks long.

Only the directed scenarios can show the values that depend on configuration. These are the exact tick on which the chip select rises and falls for each delay and early-negation setting, the wait-count arithmetic with relaxed doubling, which bank wins an overlap, mask and valid handling, the timeout tick, the timing of the external acknowledge, and the rule that a register write during an access leaves that access unchanged.

// File: rtl/cs_pkg.sv
package cs_pkg;

  localparam int BUS_W   = 32;
  localparam int CMP_LSB = 15;
  localparam int CMP_W   = BUS_W - CMP_LSB;
  localparam int SCY_W   = 4;
  localparam int CNT_W   = SCY_W + 3;

  typedef struct packed {
    logic [CMP_W-1:0] addr;
    logic [1:0]       psize;
    logic [1:0]       msel;
    logic             vld;
  } base_t;

  typedef struct packed {
    logic [CMP_W-1:0] mask;
    logic             late_neg;
    logic [1:0]       setup;
    logic             no_burst;
    logic [SCY_W-1:0] waits;
    logic             ext_mode;
    logic             relax;
    logic             bank_gap;
  } opt_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_GAP,
    ST_ACC,
    ST_MISS
  } seq_state_e;

  function automatic base_t unpack_base(input logic [BUS_W-1:0] w);
    base_t b;
    b.addr  = w[BUS_W-1:CMP_LSB];
    b.psize = w[11:10];
    b.msel  = w[7:6];
    b.vld   = w[0];
    return b;
  endfunction

  function automatic opt_t unpack_opt(input logic [BUS_W-1:0] w);
    opt_t o;
    o.mask     = w[BUS_W-1:CMP_LSB];
    o.late_neg = w[11];
    o.setup    = w[10:9];
    o.no_burst = w[8];
    o.waits    = w[7:4];
    o.ext_mode = w[3];
    o.relax    = w[2];
    o.bank_gap = w[1];
    return o;
  endfunction

endpackage

// File: rtl/cs_bank_regs.sv
module cs_bank_regs
  import cs_pkg::*;
#(
  parameter int NBANK  = 6,
  parameter int BANK_W = $clog2(NBANK)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    reg_we,
  input  logic [BANK_W:0]         reg_sel,
  input  logic [BUS_W-1:0]        reg_wdata,
  output base_t [NBANK-1:0]       base_arr,
  output opt_t  [NBANK-1:0]       opt_arr
);

  base_t wr_base;
  opt_t  wr_opt;
  logic  unused_wbits;

  assign wr_base = unpack_base(reg_wdata);
  assign wr_opt  = unpack_opt(reg_wdata);
  assign unused_wbits = ^{reg_wdata[14:12], reg_wdata[0], reg_wdata[9:8],
                          reg_wdata[5:1]};

  for (genvar i = 0; i < NBANK; i++) begin : g_bank
    logic hit_bank;
    assign hit_bank = reg_we && (reg_sel[BANK_W:1] == BANK_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_arr[i] <= '0;
        opt_arr[i]  <= '0;
      end else if (hit_bank) begin
        if (reg_sel[0]) opt_arr[i]  <= wr_opt;
        else            base_arr[i] <= wr_base;
      end
    end
  end

endmodule

// File: rtl/cs_addr_match.sv
module cs_addr_match
  import cs_pkg::*;
#(
  parameter int NBANK  = 6,
  parameter int BANK_W = $clog2(NBANK)
) (
  input  logic [BUS_W-1:0]  req_addr,
  input  base_t [NBANK-1:0] base_arr,
  input  opt_t  [NBANK-1:0] opt_arr,
  output logic              hit,
  output logic [BANK_W-1:0] hit_idx,
  output logic [1:0]        sel_ps,
  output opt_t              sel_opt
);

  logic [NBANK-1:0] claim;
  logic [CMP_LSB-1:0] unused_lo;

  assign unused_lo = req_addr[CMP_LSB-1:0];

  for (genvar i = 0; i < NBANK; i++) begin : g_cmp
    assign claim[i] = base_arr[i].vld && (base_arr[i].msel == 2'd0) &&
                      (((req_addr[BUS_W-1:CMP_LSB] ^ base_arr[i].addr) &
                        opt_arr[i].mask) == '0);
  end

  always_comb begin
    hit     = 1'b0;
    hit_idx = '0;
    for (int i = NBANK - 1; i >= 0; i--) begin
      if (claim[i]) begin
        hit     = 1'b1;
        hit_idx = BANK_W'(i);
      end
    end
  end

  assign sel_ps  = base_arr[hit_idx].psize;
  assign sel_opt = opt_arr[hit_idx];

endmodule

// File: rtl/cs_access_seq.sv
module cs_access_seq
  import cs_pkg::*;
#(
  parameter int NBANK   = 6,
  parameter int BANK_W  = $clog2(NBANK),
  parameter int TIMEOUT = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              hit,
  input  logic [BANK_W-1:0] hit_idx,
  input  logic [1:0]        sel_ps,
  input  opt_t              sel_opt,
  input  logic              ext_ack,
  output logic              req_ready,
  output logic              cs_act,
  output logic [BANK_W-1:0] cs_idx,
  output logic              oe_act,
  output logic              we_act,
  output logic [1:0]        ps_o,
  output logic              bih_o,
  output logic              ack_o,
  output logic              err_o
);

  localparam int TMO_W = $clog2(TIMEOUT + 1);

  seq_state_e         state;
  logic [CNT_W-1:0]   cnt;
  logic [CNT_W-1:0]   last_q;
  logic [1:0]         dly_q;
  logic [TMO_W-1:0]   tmo;
  logic               wr_q, neg_q, ext_q, seta_q;
  logic               have_prev;
  logic [BANK_W-1:0]  prev_idx;
  logic [SCY_W:0]     eff_waits;
  logic               unused_mask;
  logic               on, at_end, ext_done, tmo_hit;

  assign unused_mask = ^sel_opt.mask;
  assign eff_waits   = sel_opt.relax ? {sel_opt.waits, 1'b0} : {1'b0, sel_opt.waits};

  assign req_ready = (state == ST_IDLE);
  assign on        = (state == ST_ACC) && (cnt >= CNT_W'(dly_q));
  assign at_end    = !seta_q && (cnt == last_q);
  assign ext_done  = seta_q && ext_q && (cnt >= CNT_W'(3));
  assign tmo_hit   = (tmo == TMO_W'(TIMEOUT - 1));

  assign ack_o  = (state == ST_ACC) && (at_end || ext_done);
  assign err_o  = ((state == ST_MISS) && tmo_hit) ||
                  ((state == ST_ACC) && seta_q && !ext_done && tmo_hit);
  assign cs_act = on && !(neg_q && at_end);
  assign we_act = cs_act && wr_q;
  assign oe_act = on && !wr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      last_q    <= '0;
      dly_q     <= '0;
      tmo       <= '0;
      wr_q      <= 1'b0;
      neg_q     <= 1'b0;
      ext_q     <= 1'b0;
      seta_q    <= 1'b0;
      have_prev <= 1'b0;
      prev_idx  <= '0;
      cs_idx    <= '0;
      ps_o      <= '0;
      bih_o     <= 1'b0;
    end else begin
      ext_q <= ext_ack;
      unique case (state)
        ST_IDLE: begin
          if (req_valid) begin
            cnt    <= '0;
            tmo    <= '0;
            wr_q   <= req_write;
            cs_idx <= hit_idx;
            ps_o   <= sel_ps;
            bih_o  <= sel_opt.no_burst;
            neg_q  <= sel_opt.late_neg;
            seta_q <= sel_opt.ext_mode;
            last_q <= {eff_waits, 2'b11};
            dly_q  <= (sel_opt.setup == 2'd3) ? 2'd2 :
                      (sel_opt.setup == 2'd2) ? 2'd1 : 2'd0;
            if (!hit)
              state <= ST_MISS;
            else if (sel_opt.bank_gap && have_prev && (prev_idx != hit_idx))
              state <= ST_GAP;
            else
              state <= ST_ACC;
          end
        end
        ST_GAP: begin
          if (cnt == CNT_W'(3)) begin
            cnt   <= '0;
            state <= ST_ACC;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_ACC: begin
          if (cnt != '1) cnt <= cnt + 1'b1;
          if (seta_q) tmo <= tmo + 1'b1;
          if (ack_o) begin
            state     <= ST_IDLE;
            have_prev <= 1'b1;
            prev_idx  <= cs_idx;
          end else if (err_o) begin
            state <= ST_IDLE;
          end
        end
        ST_MISS: begin
          tmo <= tmo + 1'b1;
          if (err_o) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R3: every acknowledge returns the sequencer to idle on the next tick
  p_ack_then_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |=> req_ready);

  // R8: the bank-change gap lasts exactly four ticks before the access
  p_gap_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_GAP && cnt == CNT_W'(3)) |=> (state == ST_ACC && cnt == '0));

endmodule

// File: rtl/cs_timing_ctrl.sv
module cs_timing_ctrl
  import cs_pkg::*;
#(
  parameter int NBANK   = 6,
  parameter int TIMEOUT = 16,
  localparam int BANK_W = $clog2(NBANK)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [BANK_W:0]   reg_sel,
  input  logic [31:0]       reg_wdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [31:0]       req_addr,
  input  logic              req_write,
  input  logic              ext_ack,
  output logic [NBANK-1:0]  cs_n,
  output logic              oe_n,
  output logic              we_n,
  output logic [1:0]        port_size,
  output logic              burst_inh,
  output logic              bus_ack,
  output logic              bus_err
);

  base_t [NBANK-1:0] base_arr;
  opt_t  [NBANK-1:0] opt_arr;
  logic              hit;
  logic [BANK_W-1:0] hit_idx;
  logic [1:0]        sel_ps;
  opt_t              sel_opt;
  logic              cs_act, oe_act, we_act;
  logic [BANK_W-1:0] cs_idx;

  cs_bank_regs #(.NBANK(NBANK), .BANK_W(BANK_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .base_arr(base_arr), .opt_arr(opt_arr)
  );

  cs_addr_match #(.NBANK(NBANK), .BANK_W(BANK_W)) u_match (
    .req_addr(req_addr), .base_arr(base_arr), .opt_arr(opt_arr),
    .hit(hit), .hit_idx(hit_idx), .sel_ps(sel_ps), .sel_opt(sel_opt)
  );

  cs_access_seq #(.NBANK(NBANK), .BANK_W(BANK_W), .TIMEOUT(TIMEOUT)) u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .hit(hit), .hit_idx(hit_idx), .sel_ps(sel_ps), .sel_opt(sel_opt),
    .ext_ack(ext_ack), .req_ready(req_ready), .cs_act(cs_act),
    .cs_idx(cs_idx), .oe_act(oe_act), .we_act(we_act), .ps_o(port_size),
    .bih_o(burst_inh), .ack_o(bus_ack), .err_o(bus_err)
  );

  for (genvar i = 0; i < NBANK; i++) begin : g_cs
    assign cs_n[i] = !(cs_act && (cs_idx == BANK_W'(i)));
  end

  assign oe_n = !oe_act;
  assign we_n = !we_act;

  // R2: never more than one chip select low
  p_cs_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));

  // R7: read and write strobes exclusive
  p_strobe_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(!oe_n && !we_n));

  // R10: acknowledge and error never together
  p_resp_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_ack && bus_err));

  // R11: idle means no strobe and no response
  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (&cs_n && oe_n && we_n && !bus_ack));

endmodule

// File: tb/tb_cs_timing_ctrl.sv
`timescale 1ns/1ps
module tb_cs_timing_ctrl;

  localparam int NB  = 6;
  localparam int BW  = $clog2(NB);
  localparam int TMO = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_we = 1'b0;
  logic [BW:0]   reg_sel = '0;
  logic [31:0]   reg_wdata = '0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [31:0]   req_addr = '0;
  logic          req_write = 1'b0;
  logic          ext_ack = 1'b0;
  logic [NB-1:0] cs_n;
  logic          oe_n, we_n, burst_inh, bus_ack, bus_err;
  logic [1:0]    port_size;

  int n_chk = 0;
  int n_bad = 0;

  int r_cs_first, r_cs_last, r_oe_first, r_oe_last, r_we_first, r_we_last;
  int r_ack, r_err, r_bank, r_ps, r_bih, r_rdy0;

  always #2 clk = ~clk;

  cs_timing_ctrl #(.NBANK(NB), .TIMEOUT(TMO)) dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write), .ext_ack(ext_ack),
    .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n), .port_size(port_size),
    .burst_inh(burst_inh), .bus_ack(bus_ack), .bus_err(bus_err)
  );

  task automatic check(input string rq, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_base(input logic [31:0] a, input int ps,
                                          input int ms, input int v);
    return (a & 32'hFFFF8000) | (32'(ps) << 10) | (32'(ms) << 6) | 32'(v);
  endfunction

  function automatic logic [31:0] mk_opt(input logic [31:0] m, input int neg,
      input int acs, input int bih, input int scy, input int seta,
      input int trlx, input int gap);
    return (m & 32'hFFFF8000) | (32'(neg) << 11) | (32'(acs) << 9) |
           (32'(bih) << 8) | (32'(scy) << 4) | (32'(seta) << 3) |
           (32'(trlx) << 2) | (32'(gap) << 1);
  endfunction

  task automatic wr_reg(input int bank, input int is_opt, input logic [31:0] d);
    @(negedge clk);
    reg_we    = 1'b1;
    reg_sel   = (BW+1)'(bank * 2 + is_opt);
    reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic do_access(input logic [31:0] a, input logic w, input int ext_at,
                           input bit mid_wr, input int mid_bank,
                           input logic [31:0] mid_data);
    r_cs_first = -1; r_cs_last = -1; r_oe_first = -1; r_oe_last = -1;
    r_we_first = -1; r_we_last = -1; r_ack = -1; r_err = -1; r_bank = -1;
    r_ps = -1; r_bih = -1; r_rdy0 = -1;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_addr  = a;
    req_write = w;
    req_valid = 1'b1;
    if (ext_at == 0) ext_ack = 1'b1;
    for (int k = 0; k < 400; k++) begin
      @(negedge clk);
      if (k == 0) begin
        req_valid = 1'b0;
        r_rdy0 = int'(req_ready);
      end
      if (cs_n != '1) begin
        if (r_cs_first < 0) r_cs_first = k;
        r_cs_last = k;
        for (int b = 0; b < NB; b++) if (!cs_n[b]) r_bank = b;
      end
      if (!oe_n) begin if (r_oe_first < 0) r_oe_first = k; r_oe_last = k; end
      if (!we_n) begin if (r_we_first < 0) r_we_first = k; r_we_last = k; end
      if (mid_wr && k == 2) begin
        reg_we = 1'b1; reg_sel = (BW+1)'(mid_bank * 2 + 1); reg_wdata = mid_data;
      end
      if (k == 3) reg_we = 1'b0;
      if (ext_at > 0 && k == ext_at) ext_ack = 1'b1;
      if (bus_ack || bus_err) begin
        r_ps  = int'(port_size);
        r_bih = int'(burst_inh);
        if (bus_ack) r_ack = k;
        if (bus_err) r_err = k;
        break;
      end
    end
    reg_we  = 1'b0;
    ext_ack = 1'b0;
  endtask

  task automatic t_reset();
    check("R1", "cs_n", int'(cs_n), (1 << NB) - 1);
    check("R1", "oe_n", int'(oe_n), 1);
    check("R1", "we_n", int'(we_n), 1);
    check("R1", "req_ready", int'(req_ready), 1);
    check("R1", "ack|err", int'(bus_ack | bus_err), 0);
  endtask

  task automatic t_basic();
    wr_reg(0, 0, mk_base(32'h1000_0000, 2, 0, 1));
    wr_reg(0, 1, mk_opt(32'hFFFF_8000, 0, 0, 1, 2, 0, 0, 0));
    do_access(32'h1000_0000, 1'b0, -1, 1'b0, 0, 0);
    check("R3", "ack tick W=2", r_ack, 11);
    check("R5", "cs first acs0", r_cs_first, 0);
    check("R3", "cs last", r_cs_last, 11);
    check("R2", "bank", r_bank, 0);
    check("R7", "oe first", r_oe_first, 0);
    check("R7", "oe last", r_oe_last, 11);
    check("R7", "no we on read", r_we_first, -1);
    check("R12", "port size", r_ps, 2);
    check("R12", "burst inh", r_bih, 1);
    check("R11", "ready at tick0", r_rdy0, 0);
    @(negedge clk);
    check("R11", "ready after ack", int'(req_ready), 1);
    do_access(32'h1000_7FFC, 1'b1, -1, 1'b0, 0, 0);
    check("R2", "low bits ignored bank", r_bank, 0);
    check("R7", "we first", r_we_first, 0);
    check("R7", "we last", r_we_last, 11);
    check("R7", "no oe on write", r_oe_first, -1);
  endtask

  task automatic t_setup_neg();
    wr_reg(1, 0, mk_base(32'h2000_0000, 0, 0, 1));
    wr_reg(1, 1, mk_opt(32'hFFFF_8000, 1, 3, 0, 1, 0, 0, 0));
    do_access(32'h2000_0010, 1'b1, -1, 1'b0, 0, 0);
    check("R5", "cs first acs3", r_cs_first, 2);
    check("R6", "cs last early neg", r_cs_last, 6);
    check("R6", "we last early neg", r_we_last, 6);
    check("R3", "ack tick W=1", r_ack, 7);
    do_access(32'h2000_0010, 1'b0, -1, 1'b0, 0, 0);
    check("R6", "oe last full length", r_oe_last, 7);
    check("R5", "oe first with cs", r_oe_first, 2);
    check("R12", "port size 32", r_ps, 0);
    check("R12", "burst inh 0", r_bih, 0);
  endtask

  task automatic t_relaxed();
    wr_reg(2, 0, mk_base(32'h3000_0000, 0, 0, 1));
    wr_reg(2, 1, mk_opt(32'hFFFF_8000, 0, 2, 0, 3, 0, 1, 0));
    do_access(32'h3000_0000, 1'b0, -1, 1'b0, 0, 0);
    check("R4", "relaxed ack tick", r_ack, 27);
    check("R5", "cs first acs2", r_cs_first, 1);
    check("R4", "cs last", r_cs_last, 27);
  endtask

  task automatic t_reg_update();
    do_access(32'h3000_0000, 1'b0, -1, 1'b1, 2, mk_opt(32'hFFFF_8000, 0, 0, 0, 0, 0, 0, 0));
    check("R13", "in-flight ack unchanged", r_ack, 27);
    do_access(32'h3000_0000, 1'b0, -1, 1'b0, 0, 0);
    check("R13", "new ack tick", r_ack, 3);
    check("R13", "new cs first", r_cs_first, 0);
  endtask

  task automatic t_priority();
    wr_reg(3, 0, mk_base(32'h4000_0000, 0, 0, 1));
    wr_reg(3, 1, mk_opt(32'hFF00_0000, 0, 0, 0, 0, 0, 0, 0));
    wr_reg(4, 0, mk_base(32'h4000_0000, 1, 0, 1));
    wr_reg(4, 1, mk_opt(32'hFFFF_8000, 0, 0, 0, 0, 0, 0, 0));
    do_access(32'h4000_0100, 1'b0, -1, 1'b0, 0, 0);
    check("R2", "lowest bank wins", r_bank, 3);
    do_access(32'h40F0_0000, 1'b0, -1, 1'b0, 0, 0);
    check("R2", "wide mask match", r_bank, 3);
    wr_reg(3, 0, mk_base(32'h4000_0000, 0, 0, 0));
    do_access(32'h4000_0100, 1'b0, -1, 1'b0, 0, 0);
    check("R2", "invalid bank skipped", r_bank, 4);
    check("R12", "port size 8", r_ps, 1);
    do_access(32'h4000_8000, 1'b0, -1, 1'b0, 0, 0);
    check("R10", "miss err tick", r_err, TMO - 1);
    check("R10", "miss no cs", r_cs_first, -1);
    check("R10", "miss no ack", r_ack, -1);
    wr_reg(5, 0, mk_base(32'h5000_0000, 0, 2, 1));
    wr_reg(5, 1, mk_opt(32'hFFFF_8000, 0, 0, 0, 0, 0, 0, 0));
    do_access(32'h5000_0000, 1'b1, -1, 1'b0, 0, 0);
    check("R2", "nonzero machine select no cs", r_cs_first, -1);
    check("R10", "nonzero machine select err", r_err, TMO - 1);
  endtask

  task automatic t_gap();
    wr_reg(4, 1, mk_opt(32'hFFFF_8000, 0, 0, 0, 0, 0, 0, 1));
    do_access(32'h1000_0000, 1'b0, -1, 1'b0, 0, 0);
    check("R3", "bank0 before gap", r_ack, 11);
    do_access(32'h4000_0100, 1'b0, -1, 1'b0, 0, 0);
    check("R8", "gap cs first", r_cs_first, 4);
    check("R8", "gap ack", r_ack, 7);
    do_access(32'h4000_0100, 1'b0, -1, 1'b0, 0, 0);
    check("R8", "same bank no gap", r_cs_first, 0);
    check("R8", "same bank ack", r_ack, 3);
    do_access(32'h1000_0000, 1'b0, -1, 1'b0, 0, 0);
    check("R8", "gap off on new bank", r_cs_first, 0);
  endtask

  task automatic t_ext_ack();
    wr_reg(5, 0, mk_base(32'h6000_0000, 0, 0, 1));
    wr_reg(5, 1, mk_opt(32'hFFFF_8000, 1, 0, 0, 0, 1, 0, 0));
    do_access(32'h6000_0000, 1'b0, 5, 1'b0, 0, 0);
    check("R9", "ext ack tick", r_ack, 6);
    check("R9", "cs held to ack", r_cs_last, 6);
    do_access(32'h6000_0000, 1'b1, 0, 1'b0, 0, 0);
    check("R9", "early ext ack waits for tick3", r_ack, 3);
    check("R9", "we held to ack", r_we_last, 3);
    do_access(32'h6000_0000, 1'b0, -1, 1'b0, 0, 0);
    check("R10", "ext timeout err", r_err, TMO - 1);
    check("R10", "ext timeout no ack", r_ack, -1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_setup_neg();
    t_relaxed();
    t_reg_update();
    t_priority();
    t_gap();
    t_ext_ack();
    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(4 * 100000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule